// File: doc/BRIEF.md
# Interrupt Status and Return Controller

This block keeps the interrupt and mode portion of a processor status word, together with the two saved program counters and the software-interrupt pending flags. A core pipeline drives it with single-cycle request strobes: mask interrupts, unmask interrupts, return from a handler, raise a software interrupt, or load the status bits directly. Two more strobes come from the exception logic. They report an ordinary exception entry or a non-maskable entry, along with the PC to save.

On a return, the controller chooses which saved PC to hand back by looking at the non-maskable-active flag. If the flag is set, it returns through the non-maskable saved PC and clears the flag. Otherwise it returns through the exception saved PC and copies the previous enable and mode bits back into the current ones. The returned PC always has bit 0 cleared. The chosen PC leaves on `ret_pc`, qualified by a one-cycle `ret_valid` pulse. Choosing an interrupt and producing its vector is done elsewhere.

Top module: `irq_state_ctrl`

## Requirements
- R1: While reset is held low at a clock edge, the status word, the exception word, both saved PCs and `ret_valid` all become zero.
- R2: An accepted disable request clears status bit 0 and leaves every other status bit unchanged.
- R3: An accepted enable request sets status bit 0 to 1, whatever its earlier value, and leaves every other status bit unchanged.
- R4: The status word layout is fixed: bit 0 = interrupt enable (current), bit 1 = interrupt enable (previous), bit 2 = user mode (current), bit 3 = user mode (previous), bit 9 = non-maskable active. All other bits read as 0.
- R5: An accepted return while bit 9 is set drives `ret_pc` = saved non-maskable PC with bit 0 forced to 0. It also clears bit 9 and leaves bits 0 to 3 unchanged.
- R6: An accepted return while bit 9 is clear drives `ret_pc` = saved exception PC with bit 0 forced to 0. It also copies bit 1 into bit 0 and bit 3 into bit 2.
- R7: A software interrupt with index n sets bit 4+n of the exception word, which is 8 bits wide with bits 0 to 3 always 0. Set bits stay set until reset.
- R8: An exception entry saves `entry_pc` as the exception PC, copies bit 0 to bit 1 and bit 2 to bit 3, and then clears bits 0 and 2.
- R9: A non-maskable entry saves `entry_pc` as the non-maskable PC and sets bit 9. Bits 0 to 3 and the exception PC are left unchanged.
- R10: Only one event acts per cycle. The priority order, highest first, is non-maskable entry, exception entry, return, status load, enable, disable, software interrupt. Lower-priority requests in the same cycle have no effect.
- R11: Every effect shows on the outputs after the first rising edge that follows the request. `ret_valid` is high for exactly one cycle per accepted return and stays low at all other times.
- R12: An accepted status load writes bits 0 to 3 and bit 9 from `st_wdata`. All other bits of `st_wdata` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nmi_entry | input | 1 | Non-maskable exception entry strobe |
| exc_entry | input | 1 | Ordinary exception entry strobe |
| entry_pc | input | PC_W | PC to save on an entry |
| ret_req | input | 1 | Return-from-handler request |
| st_wr | input | 1 | Status load request |
| st_wdata | input | STATUS_W | Status load value |
| ei_req | input | 1 | Interrupt enable request |
| di_req | input | 1 | Interrupt disable request |
| swi_req | input | 1 | Software interrupt request |
| swi_idx | input | $clog2(SWI_N) | Software interrupt index |
| status | output | STATUS_W | Status word |
| exc_word | output | SWI_BASE+SWI_N | Exception word holding the pending bits |
| irq_en | output | 1 | Current interrupt enable |
| user_mode | output | 1 | Current user mode |
| saved_epc | output | PC_W | Saved exception PC |
| saved_npc | output | PC_W | Saved non-maskable PC |
| ret_valid | output | 1 | Return PC valid, one-cycle pulse |
| ret_pc | output | PC_W | PC to resume at after a return |

## Verification
Every result of this block is registered exactly once. A request presented before a rising edge shows its status, exception word, saved PC and `ret_pc` results right after that edge. `ret_valid` must fall again one edge later. The bench therefore drives each request on a falling edge, waits for the next rising edge, and compares on the falling edge that follows. For returns it also checks that the pulse is gone one cycle later. The priority tests raise several strobes in the same cycle and confirm that the losing requests left the status word and the exception word untouched at that same sample point.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared bit positions, action codes and mode state for the
// interrupt status and return controller. Assumes a status word of at
// least 10 bits.
package irq_ctrl_pkg;

    localparam int POS_IE_CUR = 0;
    localparam int POS_IE_PRV = 1;
    localparam int POS_UM_CUR = 2;
    localparam int POS_UM_PRV = 3;
    localparam int POS_NMI    = 9;

    // One action per cycle, chosen by the arbiter
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_NMI,
        ACT_EXC,
        ACT_RET,
        ACT_LOAD,
        ACT_EI,
        ACT_DI,
        ACT_SWI
    } act_e;

    typedef struct packed {
        logic nmi;
        logic um_prv;
        logic um_cur;
        logic ie_prv;
        logic ie_cur;
    } mode_t;

endpackage

// File: rtl/irq_cmd_arb.sv
// Fixed-priority selector: turns the request strobes into at most one
// action per cycle. Assumes strobes are already synchronous to clk.
module irq_cmd_arb
    import irq_ctrl_pkg::*;
(
    input  logic nmi_entry,
    input  logic exc_entry,
    input  logic ret_req,
    input  logic st_wr,
    input  logic ei_req,
    input  logic di_req,
    input  logic swi_req,
    output act_e act
);

    // Pick the highest-priority pending request
    always_comb begin
        if (nmi_entry)      act = ACT_NMI;
        else if (exc_entry) act = ACT_EXC;
        else if (ret_req)   act = ACT_RET;
        else if (st_wr)     act = ACT_LOAD;
        else if (ei_req)    act = ACT_EI;
        else if (di_req)    act = ACT_DI;
        else if (swi_req)   act = ACT_SWI;
        else                act = ACT_IDLE;
    end

endmodule

// File: rtl/irq_mode_reg.sv
// Mode register: holds the enable, user-mode and non-maskable flags and
// updates them for the selected action. Assumes one action per cycle.
module irq_mode_reg
    import irq_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  act_e  act,
    input  mode_t load_val,
    output mode_t mode
);

    mode_t mode_q;

    // Apply the selected action to the flag set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            case (act)
                ACT_NMI:  mode_q.nmi <= 1'b1;
                ACT_EXC: begin
                    mode_q.ie_prv <= mode_q.ie_cur;
                    mode_q.um_prv <= mode_q.um_cur;
                    mode_q.ie_cur <= 1'b0;
                    mode_q.um_cur <= 1'b0;
                end
                ACT_RET: begin
                    if (mode_q.nmi) begin
                        mode_q.nmi <= 1'b0;
                    end else begin
                        mode_q.ie_cur <= mode_q.ie_prv;
                        mode_q.um_cur <= mode_q.um_prv;
                    end
                end
                ACT_LOAD: mode_q <= load_val;
                ACT_EI:   mode_q.ie_cur <= 1'b1;
                ACT_DI:   mode_q.ie_cur <= 1'b0;
                default:  mode_q <= mode_q;
            endcase
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/irq_pc_hold.sv
// Saved PC register: captures a PC on a load strobe and holds it
// otherwise. Assumes load is a single-cycle strobe.
module irq_pc_hold #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PC_W-1:0] d,
    output logic [PC_W-1:0] q
);

    // Capture the PC on load
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/irq_swi_pend.sv
// Software interrupt pending flags: one sticky bit per index, set by a
// request and cleared only by reset.
module irq_swi_pend #(
    parameter int SWI_N = 4,
    localparam int IDX_W = (SWI_N > 1) ? $clog2(SWI_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic [IDX_W-1:0] idx,
    output logic [SWI_N-1:0] pend
);

    for (genvar g = 0; g < SWI_N; g++) begin : g_bit
        // Set this flag when its index is raised
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[g] <= 1'b0;
            else if (set && (idx == IDX_W'(g)))
                pend[g] <= 1'b1;
        end
    end

endmodule

// File: rtl/irq_state_ctrl.sv
// Top: interrupt status and return controller. Arbitrates the requests,
// keeps the mode flags, both saved PCs and the software pending bits,
// and produces the return PC. Assumes STATUS_W >= 10.
module irq_state_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int STATUS_W = 16,
    parameter int SWI_N    = 4,
    parameter int SWI_BASE = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         nmi_entry,
    input  logic                         exc_entry,
    input  logic [PC_W-1:0]              entry_pc,
    input  logic                         ret_req,
    input  logic                         st_wr,
    input  logic [STATUS_W-1:0]          st_wdata,
    input  logic                         ei_req,
    input  logic                         di_req,
    input  logic                         swi_req,
    input  logic [$clog2(SWI_N)-1:0]     swi_idx,
    output logic [STATUS_W-1:0]          status,
    output logic [SWI_BASE+SWI_N-1:0]    exc_word,
    output logic                         irq_en,
    output logic                         user_mode,
    output logic [PC_W-1:0]              saved_epc,
    output logic [PC_W-1:0]              saved_npc,
    output logic                         ret_valid,
    output logic [PC_W-1:0]              ret_pc
);

    localparam int EXC_W = SWI_BASE + SWI_N;
    localparam logic [PC_W-1:0] PC_ALIGN = {{(PC_W-1){1'b1}}, 1'b0};

    act_e             act;
    mode_t            mode;
    mode_t            load_val;
    logic [SWI_N-1:0] pend;
    logic             ret_valid_q;
    logic [PC_W-1:0]  ret_pc_q;

    irq_cmd_arb u_arb (
        .nmi_entry (nmi_entry),
        .exc_entry (exc_entry),
        .ret_req   (ret_req),
        .st_wr     (st_wr),
        .ei_req    (ei_req),
        .di_req    (di_req),
        .swi_req   (swi_req),
        .act       (act)
    );

    // Pick the defined bits out of a status load value
    always_comb begin
        load_val.ie_cur = st_wdata[POS_IE_CUR];
        load_val.ie_prv = st_wdata[POS_IE_PRV];
        load_val.um_cur = st_wdata[POS_UM_CUR];
        load_val.um_prv = st_wdata[POS_UM_PRV];
        load_val.nmi    = st_wdata[POS_NMI];
    end

    irq_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .load_val (load_val),
        .mode     (mode)
    );

    irq_pc_hold #(.PC_W(PC_W)) u_epc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (act == ACT_EXC),
        .d     (entry_pc),
        .q     (saved_epc)
    );

    irq_pc_hold #(.PC_W(PC_W)) u_npc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (act == ACT_NMI),
        .d     (entry_pc),
        .q     (saved_npc)
    );

    irq_swi_pend #(.SWI_N(SWI_N)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (act == ACT_SWI),
        .idx   (swi_idx),
        .pend  (pend)
    );

    // Register the return PC, chosen by the non-maskable flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_valid_q <= 1'b0;
            ret_pc_q    <= '0;
        end else begin
            ret_valid_q <= (act == ACT_RET);
            if (act == ACT_RET)
                ret_pc_q <= (mode.nmi ? saved_npc : saved_epc) & PC_ALIGN;
        end
    end

    // Pack the flags into the status word
    always_comb begin
        status             = '0;
        status[POS_IE_CUR] = mode.ie_cur;
        status[POS_IE_PRV] = mode.ie_prv;
        status[POS_UM_CUR] = mode.um_cur;
        status[POS_UM_PRV] = mode.um_prv;
        status[POS_NMI]    = mode.nmi;
    end

    // Place the pending flags above the base position
    always_comb begin
        exc_word = '0;
        exc_word[EXC_W-1:SWI_BASE] = pend;
    end

    assign irq_en    = mode.ie_cur;
    assign user_mode = mode.um_cur;
    assign ret_valid = ret_valid_q;
    assign ret_pc    = ret_pc_q;

endmodule

// File: rtl/irq_state_ctrl_chk.sv
// Checker for irq_state_ctrl: recomputes request acceptance from the
// ports and checks the state changes one edge later.
module irq_state_ctrl_chk #(
    parameter int PC_W     = 32,
    parameter int STATUS_W = 16,
    parameter int SWI_N    = 4,
    parameter int SWI_BASE = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      nmi_entry,
    input logic                      exc_entry,
    input logic [PC_W-1:0]           entry_pc,
    input logic                      ret_req,
    input logic                      st_wr,
    input logic [STATUS_W-1:0]       st_wdata,
    input logic                      ei_req,
    input logic                      di_req,
    input logic                      swi_req,
    input logic [$clog2(SWI_N)-1:0]  swi_idx,
    input logic [STATUS_W-1:0]       status,
    input logic [SWI_BASE+SWI_N-1:0] exc_word,
    input logic                      irq_en,
    input logic                      user_mode,
    input logic [PC_W-1:0]           saved_epc,
    input logic [PC_W-1:0]           saved_npc,
    input logic                      ret_valid,
    input logic [PC_W-1:0]           ret_pc
);

    localparam logic [STATUS_W-1:0] DEF_MASK = STATUS_W'(10'h20F);
    localparam logic [PC_W-1:0] EVEN = {{(PC_W-1){1'b1}}, 1'b0};

    logic any_entry, ok_ret, ok_load, ok_ei, ok_di, ok_swi;
    assign any_entry = nmi_entry | exc_entry;
    assign ok_ret  = ret_req & ~any_entry;
    assign ok_load = st_wr & ~ret_req & ~any_entry;
    assign ok_ei   = ei_req & ~st_wr & ~ret_req & ~any_entry;
    assign ok_di   = di_req & ~ei_req & ~st_wr & ~ret_req & ~any_entry;
    assign ok_swi  = swi_req & ~di_req & ~ei_req & ~st_wr & ~ret_req & ~any_entry;

    AST_DI_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ok_di |=> !status[0] && status[STATUS_W-1:1] == $past(status[STATUS_W-1:1])); // R2
    AST_EI_SETS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ok_ei |=> status[0] && status[STATUS_W-1:1] == $past(status[STATUS_W-1:1])); // R3
    AST_UNDEF_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~DEF_MASK) == '0 && irq_en == status[0] && user_mode == status[2]); // R4
    AST_RET_NMI_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        ok_ret && status[9] |=> ret_valid && ret_pc == ($past(saved_npc) & EVEN) && !status[9]
                                && status[3:0] == $past(status[3:0])); // R5
    AST_RET_EXC_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        ok_ret && !status[9] |=> ret_pc == ($past(saved_epc) & EVEN)
                                 && status[0] == $past(status[1]) && status[2] == $past(status[3])); // R6
    AST_SWI_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ok_swi |=> exc_word[SWI_BASE + int'($past(swi_idx))]); // R7
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (exc_word & $past(exc_word)) == $past(exc_word)); // R7
    AST_EXC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry && !nmi_entry |=> saved_epc == $past(entry_pc) && !status[0] && !status[2]
                                    && status[1] == $past(status[0]) && status[3] == $past(status[2])); // R8
    AST_NMI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_entry |=> status[9] && saved_npc == $past(entry_pc) && status[3:0] == $past(status[3:0])); // R9
    AST_NMI_OVER_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_entry && exc_entry |=> saved_epc == $past(saved_epc)); // R10
    AST_RET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $past(ok_ret)); // R11
    AST_LOAD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ok_load |=> status == ($past(st_wdata) & DEF_MASK)); // R12

endmodule

bind irq_state_ctrl irq_state_ctrl_chk #(
    .PC_W(PC_W), .STATUS_W(STATUS_W), .SWI_N(SWI_N), .SWI_BASE(SWI_BASE)
) u_chk (.*);

// File: tb/test_irq_state_ctrl.sv
module test_irq_state_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        nmi_entry, exc_entry, ret_req, st_wr, ei_req, di_req, swi_req;
    logic [31:0] entry_pc;
    logic [15:0] st_wdata;
    logic [1:0]  swi_idx;
    logic [15:0] status;
    logic [7:0]  exc_word;
    logic        irq_en, user_mode, ret_valid;
    logic [31:0] saved_epc, saved_npc, ret_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_state_ctrl i_irq_state_ctrl (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        nmi_entry = 0; exc_entry = 0; ret_req = 0; st_wr = 0;
        ei_req = 0; di_req = 0; swi_req = 0;
        entry_pc = '0; st_wdata = '0; swi_idx = '0;
    endtask

    // One request window: inputs set at a falling edge, result sampled at the next one
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk("R1 status", 32'(status), 0);
        chk("R1 exc_word", 32'(exc_word), 0);
        chk("R1 ret_valid", 32'(ret_valid), 0);
        chk("R1 saved_epc", saved_epc, 0);
        chk("R1 saved_npc", saved_npc, 0);
    endtask

    task automatic t_enable();
        ei_req = 1; step();
        chk("R3 enable", 32'(status), 32'h001);
        chk("R3 irq_en", 32'(irq_en), 1);
        ei_req = 1; step();
        chk("R3 enable when set", 32'(status), 32'h001);
    endtask

    task automatic t_exc_entry();
        exc_entry = 1; entry_pc = 32'h1235; step();
        chk("R8 status", 32'(status), 32'h002);
        chk("R8 epc", saved_epc, 32'h1235);
    endtask

    task automatic t_disable();
        ei_req = 1; step();
        chk("R3 enable keeps prev", 32'(status), 32'h003);
        di_req = 1; step();
        chk("R2 disable", 32'(status), 32'h002);
    endtask

    task automatic t_ret_exc();
        ret_req = 1; step();
        chk("R6 ret_valid", 32'(ret_valid), 1);
        chk("R6 ret_pc even", ret_pc, 32'h1234);
        chk("R6 status restore", 32'(status), 32'h003);
        step();
        chk("R11 pulse ends", 32'(ret_valid), 0);
    endtask

    task automatic t_load();
        st_wr = 1; st_wdata = 16'hFFFF; step();
        chk("R12 load masked", 32'(status), 32'h20F);
        chk("R4 user_mode", 32'(user_mode), 1);
        st_wr = 1; st_wdata = 16'h000A; step();
        chk("R12 load", 32'(status), 32'h00A);
    endtask

    task automatic t_nmi();
        nmi_entry = 1; entry_pc = 32'h2001; step();
        chk("R9 status", 32'(status), 32'h20A);
        chk("R9 npc", saved_npc, 32'h2001);
        chk("R9 epc kept", saved_epc, 32'h1235);
        ret_req = 1; step();
        chk("R5 ret_pc", ret_pc, 32'h2000);
        chk("R5 status", 32'(status), 32'h00A);
        ret_req = 1; step();
        chk("R6 ret_pc", ret_pc, 32'h1234);
        chk("R6 user restore", 32'(status), 32'h00F);
    endtask

    task automatic t_exc_user();
        exc_entry = 1; entry_pc = 32'h40; step();
        chk("R8 user entry", 32'(status), 32'h00A);
        chk("R8 epc", saved_epc, 32'h40);
    endtask

    task automatic t_swi();
        swi_req = 1; swi_idx = 2; step();
        chk("R7 swi2", 32'(exc_word), 32'h40);
        swi_req = 1; swi_idx = 0; step();
        chk("R7 swi0", 32'(exc_word), 32'h50);
        swi_req = 1; swi_idx = 3; step();
        chk("R7 swi3", 32'(exc_word), 32'hD0);
        swi_req = 1; swi_idx = 2; step();
        chk("R7 swi repeat", 32'(exc_word), 32'hD0);
    endtask

    task automatic t_priority();
        ret_req = 1; ei_req = 1; swi_req = 1; swi_idx = 1; step();
        chk("R10 ret wins pc", ret_pc, 32'h40);
        chk("R10 ret wins status", 32'(status), 32'h00F);
        chk("R10 swi dropped", 32'(exc_word), 32'hD0);
        di_req = 1; swi_req = 1; swi_idx = 1; step();
        chk("R10 di wins", 32'(status), 32'h00E);
        chk("R10 swi dropped 2", 32'(exc_word), 32'hD0);
        exc_entry = 1; ret_req = 1; entry_pc = 32'h80; step();
        chk("R10 exc over ret valid", 32'(ret_valid), 0);
        chk("R10 exc over ret status", 32'(status), 32'h008);
        chk("R10 exc over ret epc", saved_epc, 32'h80);
        nmi_entry = 1; exc_entry = 1; entry_pc = 32'h300; step();
        chk("R10 nmi npc", saved_npc, 32'h300);
        chk("R10 nmi epc kept", saved_epc, 32'h80);
        chk("R10 nmi status", 32'(status), 32'h208);
    endtask

    initial begin
        t_reset();
        t_enable();
        t_exc_entry();
        t_disable();
        t_ret_exc();
        t_load();
        t_nmi();
        t_exc_user();
        t_swi();
        t_priority();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule